// File: doc/BRIEF.md
# Three-Channel Reloadable Down-Count Timer

This peripheral holds three independent 32-bit down-counters behind a small synchronous register bus. Each channel has a live count register, a reload constant and a control register. The control register picks a power-of-four prescale ratio of the peripheral clock, carries an interrupt enable and carries a sticky underflow flag. A shared start register lets each channel count or freezes it.

A step taken while the count is zero does not wrap to all ones. It loads the channel's reload constant and sets the underflow flag. The flag stays set until software clears it. Each channel drives its own interrupt line, which is high while both its flag and its enable are set. Reads are combinational, so software always sees the live count.

Top module: `tri_timer`

## Requirements
- R1: After reset every reload constant and every count register reads 0xFFFFFFFF. Every control register, the start register and the output-control register read 0, and all interrupt lines are low.
- R2: Control bits [2:0] hold the prescale code. Code c (0 to 4) makes the count step once every 4^(c+1) clock cycles. The first step comes 4^(c+1) rising edges after the edge that sets the start bit.
- R3: With code 5, 6 or 7 selected, the channel never steps, even when its start bit is set.
- R4: A step taken while the count is 0 loads the count from the reload constant and sets the underflow flag at control bit 8. Any other step subtracts 1.
- R5: Control bit 5 is the interrupt enable. Channel n's interrupt line is high exactly while its flag and its enable are both set.
- R6: Start bit n (offset 0x04, bits [2:0]) lets channel n count. A cleared bit freezes the count and leaves the other channels untouched. Stopping a channel clears its prescale phase, so after a restart the first step takes a full period.
- R7: A write to a count register takes effect at once, even while the channel runs. Counting continues from the written value with the prescale phase kept. If the write lands on a step edge, the write wins and that step is dropped.
- R8: Writing 0 to control bit 8 clears the flag, and writing 1 leaves it as it was. An underflow on the same edge as a clearing write leaves the flag set.
- R9: A control write that changes the prescale code clears the prescale phase, so the next step comes one full new period after that write.
- R10: Offsets per channel n are: reload 0x08+12n, count 0x0C+12n, control 0x10+12n. The control register reads back only bits [2:0], 5 and 8. Offset 0x00 stores bit 0 only. Offset 0x2C reads 0 and ignores writes.
- R11: A read returns the register's present value in the same cycle as the address, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
A register write is taken on the rising edge after it is presented. Its effect shows on the following low clock phase. A read returns data within the same low phase, with no added latency. A count step comes exactly 4^(c+1) edges after a start or a code change, so the bench numbers every edge after the start write and expects floor(k/period) steps at edge k. It replays those steps arithmetically for the expected count, flag and interrupt. The bench times priority-sensitive writes to land on a known step or underflow edge, and it reads back on the next low phase.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  localparam int CODE_W     = 3;
  localparam int MAX_CODE   = 4;
  localparam int PS_W       = 2 * (MAX_CODE + 1);
  localparam int DATA_W     = 32;
  localparam int OUTCTL_W   = 1;

  localparam int OFS_OUTCTL = 'h00;
  localparam int OFS_START  = 'h04;
  localparam int OFS_CH0    = 'h08;
  localparam int CH_STRIDE  = 12;
  localparam int REL_OFS    = 0;
  localparam int CNT_OFS    = 4;
  localparam int CTL_OFS    = 8;

  localparam int BIT_IE     = 5;
  localparam int BIT_FLAG   = 8;

  // Codes above MAX_CODE are clock sources this block does not provide.
  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return int'(c) <= MAX_CODE;
  endfunction

  // Terminal prescale count: 4^(c+1) - 1.
  function automatic logic [PS_W-1:0] ps_last(input logic [CODE_W-1:0] c);
    int unsigned v;
    v = (32'd1 << (2 * (int'(c) + 1))) - 32'd1;
    return PS_W'(v);
  endfunction

  function automatic logic [DATA_W-1:0] ctl_word(input logic [CODE_W-1:0] c,
                                                  input logic ie, input logic fl);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CODE_W-1:0] = c;
    w[BIT_IE]     = ie;
    w[BIT_FLAG]   = fl;
    return w;
  endfunction

endpackage

// File: rtl/tri_timer_prescale.sv
module tri_timer_prescale
  import tri_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [PS_W-1:0] ps_q;
  logic            at_last;

  assign at_last = (ps_q == ps_last(code));
  assign tick    = run && !restart && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)                ps_q <= '0;
    else if (!run || restart)  ps_q <= '0;
    else if (at_last)          ps_q <= '0;
    else                       ps_q <= ps_q + 1'b1;
  end

endmodule

// File: rtl/tri_timer_channel.sv
module tri_timer_channel
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rel_wr,
  input  logic              cnt_wr,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  rel_q,
  output logic [CODE_W-1:0] code_q,
  output logic              ie_q,
  output logic              flag_q,
  output logic              tick,
  output logic              uf,
  output logic              irq
);

  logic run, restart;

  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] c,
                                                   input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  assign run     = start && code_ok(code_q);
  assign restart = ctl_wr && (wdata[CODE_W-1:0] != code_q);

  tri_timer_prescale u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .code    (code_q),
    .tick    (tick)
  );

  // A software write to the count wins over a step on the same edge.
  assign uf  = tick && (cnt_q == '0) && !cnt_wr;
  assign irq = flag_q && ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_wr) cnt_q <= wdata[CNT_W-1:0];
    else if (tick)   cnt_q <= step_value(cnt_q, rel_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rel_q <= '1;
    else if (rel_wr) rel_q <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      ie_q   <= 1'b0;
    end else if (ctl_wr) begin
      code_q <= wdata[CODE_W-1:0];
      ie_q   <= wdata[BIT_IE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         flag_q <= 1'b0;
    else if (uf)                        flag_q <= 1'b1;
    else if (ctl_wr && !wdata[BIT_FLAG]) flag_q <= 1'b0;
  end

endmodule

// File: rtl/tri_timer_decode.sv
module tri_timer_decode
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8
)(
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_outctl,
  output logic              hit_start,
  output logic [NUM_CH-1:0] hit_rel,
  output logic [NUM_CH-1:0] hit_cnt,
  output logic [NUM_CH-1:0] hit_ctl
);

  assign hit_outctl = (addr == ADDR_W'(OFS_OUTCTL));
  assign hit_start  = (addr == ADDR_W'(OFS_START));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = OFS_CH0 + CH_STRIDE * i;
    assign hit_rel[i] = (addr == ADDR_W'(BASE + REL_OFS));
    assign hit_cnt[i] = (addr == ADDR_W'(BASE + CNT_OFS));
    assign hit_ctl[i] = (addr == ADDR_W'(BASE + CTL_OFS));
  end

endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  logic                  wr_en;
  logic                  hit_outctl, hit_start;
  logic [NUM_CH-1:0]     hit_rel, hit_cnt, hit_ctl;
  logic [OUTCTL_W-1:0]   outctl_q;
  logic [NUM_CH-1:0]     start_q;

  logic [NUM_CH-1:0]              ch_tick, ch_uf, ch_flag, ch_ie;
  logic [NUM_CH-1:0]              ch_cnt_wr, ch_ctl_wr, ch_rel_wr;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt, ch_rel;
  logic [NUM_CH-1:0][CODE_W-1:0]  ch_code;

  assign wr_en = bus_sel && bus_we;

  tri_timer_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr       (bus_addr),
    .hit_outctl (hit_outctl),
    .hit_start  (hit_start),
    .hit_rel    (hit_rel),
    .hit_cnt    (hit_cnt),
    .hit_ctl    (hit_ctl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outctl_q <= '0;
      start_q  <= '0;
    end else begin
      if (wr_en && hit_outctl) outctl_q <= bus_wdata[OUTCTL_W-1:0];
      if (wr_en && hit_start)  start_q  <= bus_wdata[NUM_CH-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_rel_wr[i] = wr_en && hit_rel[i];
    assign ch_cnt_wr[i] = wr_en && hit_cnt[i];
    assign ch_ctl_wr[i] = wr_en && hit_ctl[i];

    tri_timer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_q[i]),
      .rel_wr (ch_rel_wr[i]),
      .cnt_wr (ch_cnt_wr[i]),
      .ctl_wr (ch_ctl_wr[i]),
      .wdata  (bus_wdata),
      .cnt_q  (ch_cnt[i]),
      .rel_q  (ch_rel[i]),
      .code_q (ch_code[i]),
      .ie_q   (ch_ie[i]),
      .flag_q (ch_flag[i]),
      .tick   (ch_tick[i]),
      .uf     (ch_uf[i]),
      .irq    (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_outctl) bus_rdata = 32'(outctl_q);
    if (hit_start)  bus_rdata = 32'(start_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_rel[i]) bus_rdata = 32'(ch_rel[i]);
      if (hit_cnt[i]) bus_rdata = 32'(ch_cnt[i]);
      if (hit_ctl[i]) bus_rdata = ctl_word(ch_code[i], ch_ie[i], ch_flag[i]);
    end
  end

endmodule

// File: rtl/tri_timer_checker.sv
module tri_timer_checker
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32
)(
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CH-1:0]             start_q,
  input logic [NUM_CH-1:0]             ch_tick,
  input logic [NUM_CH-1:0]             ch_uf,
  input logic [NUM_CH-1:0]             ch_flag,
  input logic [NUM_CH-1:0]             ch_ie,
  input logic [NUM_CH-1:0]             ch_cnt_wr,
  input logic [NUM_CH-1:0]             ch_ctl_wr,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_rel,
  input logic [NUM_CH-1:0][CODE_W-1:0] ch_code,
  input logic [NUM_CH-1:0]             irq
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_tick_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |-> (start_q[i] && int'(ch_code[i]) <= MAX_CODE));

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |=> !ch_tick[i]);

    p_reserved_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ch_code[i]) > MAX_CODE && !ch_cnt_wr[i]) |=> $stable(ch_cnt[i]));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_uf[i] |=> (ch_cnt[i] == $past(ch_rel[i])));

    p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_uf[i] |=> (irq[i] == ch_ie[i]));

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[i] && !ch_cnt_wr[i]) |=> $stable(ch_cnt[i]));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_uf[i] |=> ch_flag[i]);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_flag[i]) |-> $past(ch_ctl_wr[i]));
  end

endmodule

bind tri_timer tri_timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_q   (start_q),
  .ch_tick   (ch_tick),
  .ch_uf     (ch_uf),
  .ch_flag   (ch_flag),
  .ch_ie     (ch_ie),
  .ch_cnt_wr (ch_cnt_wr),
  .ch_ctl_wr (ch_ctl_wr),
  .ch_cnt    (ch_cnt),
  .ch_rel    (ch_rel),
  .ch_code   (ch_code),
  .irq       (irq)
);

// File: tb/tri_timer_test.sv
module tri_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tri_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic [7:0] rel_a(input int ch); return 8'(8 + 12*ch);  endfunction
  function automatic [7:0] cnt_a(input int ch); return 8'(12 + 12*ch); endfunction
  function automatic [7:0] ctl_a(input int ch); return 8'(16 + 12*ch); endfunction

  // Count after s steps from v with reload r.
  function automatic [31:0] model_cnt(input [31:0] v, input [31:0] r, input int s);
    logic [31:0] x;
    x = v;
    for (int j = 0; j < s; j++) x = (x == 0) ? r : x - 1;
    return x;
  endfunction

  task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called in the low phase; lands on the next rising edge, returns on the next low phase.
  task automatic wr(input [7:0] a, input [31:0] d);
    bus_addr = a; bus_wdata = d; bus_sel = 1; bus_we = 1;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input [7:0] a, output [31:0] d);
    bus_addr = a; bus_sel = 1; bus_we = 0;
    #1;
    d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, other0, other1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < 3; ch++) begin
      rd(rel_a(ch), d); chk("R1 reload", d, 32'hFFFF_FFFF);
      rd(cnt_a(ch), d); chk("R1 count", d, 32'hFFFF_FFFF);
      rd(ctl_a(ch), d); chk("R1 control", d, 0);
    end
    rd(8'h04, d); chk("R1 start", d, 0);
    rd(8'h00, d); chk("R1 outctl", d, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 R4 R5 R11: sweep every channel through every valid code, each edge checked
    for (int ch = 0; ch < 3; ch++) begin
      for (int code = 0; code < 5; code++) begin
        int p;
        p = 1 << (2*code + 2);
        wr(8'h04, 0);
        wr(rel_a(ch), 2);
        wr(cnt_a(ch), 1);
        wr(ctl_a(ch), 32'h20 | code);
        rd(cnt_a((ch+1)%3), other0);
        wr(8'h04, 1 << ch);
        for (int k = 1; k <= 6*p; k++) begin
          int s;
          @(negedge clk);
          s = k / p;
          rd(cnt_a(ch), d);
          chk("R2 R4 R11 count step", d, model_cnt(1, 2, s));
          chk("R5 irq", 32'(irq[ch]), (s >= 2) ? 1 : 0);
        end
        rd(ctl_a(ch), d);
        chk("R4 flag bit8", d, 32'h120 | code);
        wr(8'h04, 0);
        repeat (20) @(negedge clk);
        rd(cnt_a(ch), d); chk("R6 frozen", d, model_cnt(1, 2, 6));
        rd(cnt_a((ch+1)%3), other1); chk("R6 other channel", other1, other0);
      end
    end

    // R3 reserved codes do not count
    for (int code = 5; code < 8; code++) begin
      wr(8'h04, 0);
      wr(ctl_a(0), code);
      wr(cnt_a(0), 100);
      wr(8'h04, 1);
      repeat (40) @(negedge clk);
      rd(cnt_a(0), d); chk("R3 reserved code hold", d, 100);
    end
    wr(8'h04, 0);

    // R7 count write while running
    wr(rel_a(1), 50);
    wr(cnt_a(1), 20);
    wr(ctl_a(1), 0);
    wr(8'h04, 2);                          // edge 0
    repeat (5) @(negedge clk);             // k = 5
    rd(cnt_a(1), d); chk("R7 before write", d, 19);
    wr(cnt_a(1), 7);                       // lands at edge 6
    for (int k = 6; k <= 13; k++) begin
      if (k > 6) @(negedge clk);
      rd(cnt_a(1), d); chk("R7 continue from written", d, 32'(7 - (k/4 - 1)));
    end
    repeat (2) @(negedge clk);             // k = 15
    wr(cnt_a(1), 30);                      // lands on step edge 16
    rd(cnt_a(1), d); chk("R7 write wins step", d, 30);
    repeat (3) @(negedge clk);             // k = 19
    rd(cnt_a(1), d); chk("R7 no early step", d, 30);
    @(negedge clk);                        // k = 20
    rd(cnt_a(1), d); chk("R7 next step", d, 29);
    wr(8'h04, 0);

    // R8 R5 flag handling
    wr(rel_a(2), 9);
    wr(cnt_a(2), 0);
    wr(ctl_a(2), 32'h20);
    wr(8'h04, 4);                          // edge 0, underflow at edge 4
    repeat (3) @(negedge clk);             // k = 3
    wr(ctl_a(2), 32'h20);                  // clearing write on underflow edge
    rd(ctl_a(2), d); chk("R8 underflow beats clear", d, 32'h120);
    chk("R5 irq on", 32'(irq[2]), 1);
    rd(cnt_a(2), d); chk("R4 reload", d, 9);
    wr(ctl_a(2), 32'h120);                 // k = 5, writing 1 keeps flag
    rd(ctl_a(2), d); chk("R8 write one keeps", d, 32'h120);
    wr(ctl_a(2), 32'h20);                  // k = 6, clear
    rd(ctl_a(2), d); chk("R8 clear", d, 32'h20);
    chk("R5 irq off", 32'(irq[2]), 0);
    wr(ctl_a(2), 32'h100);                 // k = 7, ie off, writing 1 keeps flag clear
    rd(ctl_a(2), d); chk("R8 write one on clear flag", d, 0);
    repeat (37) @(negedge clk);            // k = 44, second underflow
    rd(ctl_a(2), d); chk("R4 second underflow", d, 32'h100);
    chk("R5 masked irq", 32'(irq[2]), 0);
    wr(ctl_a(2), 32'h120);
    chk("R5 enable shows irq", 32'(irq[2]), 1);
    wr(8'h04, 0);
    wr(ctl_a(2), 0);

    // R9 code change restarts the prescale phase
    wr(rel_a(0), 32'h80);
    wr(cnt_a(0), 50);
    wr(ctl_a(0), 1);
    wr(8'h04, 1);                          // edge 0
    repeat (10) @(negedge clk);            // k = 10
    wr(ctl_a(0), 0);                       // lands at edge 11
    for (int k = 11; k <= 20; k++) begin
      if (k > 11) @(negedge clk);
      rd(cnt_a(0), d); chk("R9 new period", d, 32'(50 - (k-11)/4));
    end
    wr(8'h04, 0);

    // R6 stop then restart restarts the phase
    wr(cnt_a(0), 40);
    wr(8'h04, 1);                          // edge 0
    repeat (2) @(negedge clk);             // k = 2
    wr(8'h04, 0);                          // edge 3
    wr(8'h04, 1);                          // edge 4
    for (int k = 4; k <= 11; k++) begin
      if (k > 4) @(negedge clk);
      rd(cnt_a(0), d); chk("R6 restart phase", d, (k >= 8) ? 39 : 40);
    end
    wr(8'h04, 0);

    // R10 map details
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R10 outctl bit0", d, 1);
    wr(8'h04, 32'hFFFF_FFF8);
    rd(8'h04, d); chk("R10 start bits", d, 0);
    wr(8'h2C, 32'h1234_5678);
    rd(8'h2C, d); chk("R10 dummy reads zero", d, 0);
    wr(ctl_a(1), 32'h0000_FFFF);
    rd(ctl_a(1), d); chk("R10 control fields", d, 32'h27);
    rd(rel_a(1), d); chk("R10 reload offset", d, 50);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule